// File: doc/BRIEF.md
# Swept-Duty Oscillator Bitstream Source

This block produces a one-bit-per-clock stream that stands in for the output of a sigma-delta converter. It is meant for test benches and bring-up logic. A 32-bit phase accumulator adds a frequency word on every enabled clock. The carry out of that add is the output bit, so over a long window the fraction of ones equals the word divided by 2^32.

The frequency word is not fixed. It moves in steps between a lower and an upper limit, so the duty of the stream sweeps slowly across a range. The natural limits are 1/7 and 6/7 of full scale (0x24924924 and 0xDB6DB6DB), which cover the usable span of a converter whose duty resolves in sevenths. A smaller step, or a longer interval between steps, keeps successive readings closer together.

A mode input sets what happens at the top limit. In bounce mode the sweep turns round at each limit. In wrap mode it jumps back to the lower limit. While the block is disabled it parks: the accumulator, the step timer and the direction are cleared, and the word is loaded from the lower limit.

Top module: `nco_ramp_gen`

## Requirements
- R1: While rst_ni is low, word_o is 0 and bit_o is 0.
- R2: On every clock with en_i low, the block clears the phase accumulator, the step timer and the direction (direction becomes rising). From the next clock on, word_o equals lo_word_i and bit_o is 0.
- R3: On every clock with en_i high, the accumulator adds word_o modulo 2^32. bit_o, which is registered, shows the carry out of that add. Over any 2^k consecutive enabled clocks with a constant word W, the number of ones is floor(W*2^k/2^32) or one more. A word of 0 gives no ones.
- R4: The step is applied once every interval_i+1 enabled clocks. The first step lands on the (interval_i+1)-th enabled clock after enable. Between steps word_o does not change.
- R5: In bounce mode (bounce_i=1), a step while rising sets word_o to word_o+step_i, unless that sum is at or above hi_word_i. In that case word_o becomes hi_word_i and the direction becomes falling.
- R6: In bounce mode, a step while falling sets word_o to word_o-step_i, unless word_o is at or below lo_word_i+step_i. In that case word_o becomes lo_word_i and the direction becomes rising.
- R7: In wrap mode (bounce_i=0), a step sets word_o to lo_word_i if word_o+step_i is above hi_word_i, and otherwise to word_o+step_i. The direction is forced to rising.
- R8: When lo_word_i <= hi_word_i and word_o starts inside that range, every step leaves word_o inside the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low parks the block |
| lo_word_i | input | 32 | Lower limit of the frequency word |
| hi_word_i | input | 32 | Upper limit of the frequency word |
| step_i | input | 32 | Amount added to or taken from the word per step |
| interval_i | input | 16 | Number of clocks between steps, minus one |
| bounce_i | input | 1 | 1: reverse at the limits, 0: wrap to the lower limit |
| bit_o | output | 1 | Carry-out bitstream |
| word_o | output | 32 | Current frequency word |

## Verification
Assertions check the following on every cycle: the parked state (word follows the lower limit, no ones are emitted), that the word holds between steps, that steps are spaced apart for a nonzero interval, that a zero word emits no ones, and that a step starting inside the limits stays inside them. Some behaviour only the bench scenarios can show. These are the exact sequence of words through a bounce and through a wrap, the step cadence measured in clocks, and the duty of the stream. Duty is measured as a ones count over 1024 clocks at 1/7, 1/2 and 6/7 of full scale.

// File: rtl/nco_ramp_pkg.sv
package nco_ramp_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/ramp_tick.sv
module ramp_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] interval_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= so that shrinking the interval mid-count still fires
  assign tick_o = en_i && (cnt_q >= interval_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && interval_i != '0) |=> (!tick_o || interval_i == '0));
endmodule

// File: rtl/freq_ramp.sv
module freq_ramp
  import nco_ramp_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              bounce_i,
  input  logic [WORD_W-1:0] lo_i,
  input  logic [WORD_W-1:0] hi_i,
  input  logic [WORD_W-1:0] step_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q, word_d;
  ramp_dir_e         dir_q, dir_d;
  logic [WORD_W:0]   up_sum, lo_plus;

  // one extra bit so the limit compares never wrap
  assign up_sum  = {1'b0, word_q} + {1'b0, step_i};
  assign lo_plus = {1'b0, lo_i} + {1'b0, step_i};

  always_comb begin
    word_d = word_q;
    dir_d  = dir_q;
    if (!en_i) begin
      word_d = lo_i;
      dir_d  = DIR_UP;
    end else if (tick_i) begin
      if (!bounce_i) begin
        dir_d  = DIR_UP;
        word_d = (up_sum > {1'b0, hi_i}) ? lo_i : up_sum[WORD_W-1:0];
      end else if (dir_q == DIR_UP) begin
        if (up_sum >= {1'b0, hi_i}) begin
          word_d = hi_i;
          dir_d  = DIR_DOWN;
        end else begin
          word_d = up_sum[WORD_W-1:0];
        end
      end else begin
        if ({1'b0, word_q} <= lo_plus) begin
          word_d = lo_i;
          dir_d  = DIR_UP;
        end else begin
          word_d = word_q - step_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      dir_q  <= DIR_UP;
    end else begin
      word_q <= word_d;
      dir_q  <= dir_d;
    end
  end

  assign word_o = word_q;

  // R2
  park_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (word_q == $past(lo_i)));

  // R4
  hold_between_steps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(word_q));

  // R8
  stay_in_limits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && lo_i <= hi_i && word_q >= lo_i && word_q <= hi_i)
      |=> (word_q >= $past(lo_i) && word_q <= $past(hi_i)));
endmodule

// File: rtl/phase_acc.sv
module phase_acc #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] phase_q;
  logic [WORD_W:0]   sum;
  logic              bit_q;

  assign sum = {1'b0, phase_q} + {1'b0, word_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      bit_q   <= 1'b0;
    end else if (!en_i) begin
      phase_q <= '0;
      bit_q   <= 1'b0;
    end else begin
      phase_q <= sum[WORD_W-1:0];
      bit_q   <= sum[WORD_W];
    end
  end

  assign bit_o = bit_q;

  // R2
  quiet_when_parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !bit_q);

  // R3
  zero_word_no_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && word_i == '0) |=> !bit_q);
endmodule

// File: rtl/nco_ramp_gen.sv
module nco_ramp_gen #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WORD_W-1:0] lo_word_i,
  input  logic [WORD_W-1:0] hi_word_i,
  input  logic [WORD_W-1:0] step_i,
  input  logic [DIV_W-1:0]  interval_i,
  input  logic              bounce_i,
  output logic              bit_o,
  output logic [WORD_W-1:0] word_o
);
  logic tick;
  logic [WORD_W-1:0] word;

  ramp_tick #(.DIV_W(DIV_W)) i_ramp_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .interval_i (interval_i),
    .tick_o     (tick)
  );

  freq_ramp #(.WORD_W(WORD_W)) i_freq_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .tick_i   (tick),
    .bounce_i (bounce_i),
    .lo_i     (lo_word_i),
    .hi_i     (hi_word_i),
    .step_i   (step_i),
    .word_o   (word)
  );

  phase_acc #(.WORD_W(WORD_W)) i_phase_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .word_i (word),
    .bit_o  (bit_o)
  );

  assign word_o = word;

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (word_o == '0 && !bit_o));
endmodule

// File: tb/test_nco_ramp_gen.sv
module test_nco_ramp_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0;
  logic [31:0] lo = '0, hi = '0, step = '0;
  logic [15:0] interval = '0;
  logic        bounce = 1'b0;
  logic        bit_o;
  logic [31:0] word_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [31:0] w;
    int          gap;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  bit          mon_on = 1'b0;
  logic [31:0] last_w;
  int          gap_cnt;

  always #5 clk = ~clk;

  nco_ramp_gen i_nco_ramp_gen (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .lo_word_i  (lo),
    .hi_word_i  (hi),
    .step_i     (step),
    .interval_i (interval),
    .bounce_i   (bounce),
    .bit_o      (bit_o),
    .word_o     (word_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w, input int gap, input string req);
    exp_t e;
    e.w = w; e.gap = gap; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: pops one expected item per observed word change
  always @(negedge clk) begin
    if (mon_on) begin
      gap_cnt++;
      if (word_o != last_w) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected step", longint'(word_o), longint'(last_w));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(word_o == e.w, e.req, longint'(word_o), longint'(e.w));
          chk(gap_cnt == e.gap, "R4 step spacing", gap_cnt, e.gap);
          chk(word_o >= lo && word_o <= hi, "R8 within limits", longint'(word_o), longint'(lo));
        end
        last_w  = word_o;
        gap_cnt = 0;
      end
    end
  end

  task automatic start_run();
    @(negedge clk);
    #1;
    en      = 1'b1;
    last_w  = word_o;
    gap_cnt = 0;
    mon_on  = 1'b1;
  endtask

  task automatic stop_run(input int cycles);
    repeat (cycles) @(negedge clk);
    #1;
    mon_on = 1'b0;
    en     = 1'b0;
    chk(exp_q.size() == 0, "R4 all steps seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic duty_check(input logic [31:0] w, input string req);
    longint lo_cnt;
    int ones;
    @(negedge clk);
    en = 1'b0; bounce = 1'b0; lo = w; hi = w; step = '0; interval = '0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    repeat (3) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (bit_o) ones++;
    end
    lo_cnt = (longint'(w) * 1024) >> 32;
    chk(ones == lo_cnt || ones == lo_cnt + 1, req, ones, lo_cnt);
    en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(word_o == 32'd0, "R1 word at reset", longint'(word_o), 0);
    chk(bit_o == 1'b0, "R1 bit at reset", bit_o, 0);
    rst_ni = 1'b1;

    // R2 parked: word follows lower limit, no ones
    lo = 32'd12345; hi = 32'd99999; step = 32'd7; en = 1'b0;
    repeat (2) @(negedge clk);
    chk(word_o == 32'd12345, "R2 parked word", longint'(word_o), 12345);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(bit_o == 1'b0, "R2 parked bit", bit_o, 0);
    end
    lo = 32'd777;
    @(negedge clk);
    chk(word_o == 32'd777, "R2 parked word tracks", longint'(word_o), 777);

    // R3 duty at fixed words
    duty_check(32'h2492_4924, "R3 duty 1/7");
    duty_check(32'h8000_0000, "R3 duty 1/2");
    duty_check(32'hDB6D_B6DB, "R3 duty 6/7");
    duty_check(32'h0000_0000, "R3 duty zero");

    // R5 R6 bounce sweep, step every 4 clocks
    @(negedge clk);
    en = 1'b0; bounce = 1'b1; lo = 32'd1000; hi = 32'd1100; step = 32'd30; interval = 16'd3;
    repeat (2) @(negedge clk);
    chk(word_o == 32'd1000, "R2 start at lower limit", longint'(word_o), 1000);
    push(32'd1030, 4, "R5 rise");
    push(32'd1060, 4, "R5 rise");
    push(32'd1090, 4, "R5 rise");
    push(32'd1100, 4, "R5 clamp at upper limit");
    push(32'd1070, 4, "R6 fall");
    push(32'd1040, 4, "R6 fall");
    push(32'd1010, 4, "R6 fall");
    push(32'd1000, 4, "R6 clamp at lower limit");
    push(32'd1030, 4, "R6 rise again");
    start_run();
    stop_run(38);

    // R7 wrap sweep, step every clock
    @(negedge clk);
    bounce = 1'b0; lo = 32'd1000; hi = 32'd1100; step = 32'd50; interval = 16'd0;
    repeat (2) @(negedge clk);
    push(32'd1050, 1, "R7 rise");
    push(32'd1100, 1, "R7 reach upper limit exactly");
    push(32'd1000, 1, "R7 wrap to lower limit");
    push(32'd1050, 1, "R7 rise");
    push(32'd1100, 1, "R7 reach upper limit exactly");
    push(32'd1000, 1, "R7 wrap to lower limit");
    start_run();
    stop_run(6);

    // R4 longer interval
    @(negedge clk);
    bounce = 1'b0; lo = 32'd0; hi = 32'hFFFF_FFFF; step = 32'd5; interval = 16'd9;
    repeat (2) @(negedge clk);
    push(32'd5, 10, "R4 step after 10 clocks");
    push(32'd10, 10, "R4 step after 10 clocks");
    push(32'd15, 10, "R4 step after 10 clocks");
    start_run();
    stop_run(35);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule